// File: doc/BRIEF.md
# Paged RAM and ROM address generator

This block builds the memory addresses for a small nibble-oriented processor. A 4-bit up-counter supplies the low address bits and an 8-bit page pointer supplies the eight bits above them. Data RAM is therefore seen as 256 fixed objects of 16 locations each. The pointer selects the object, and the counter walks through it, either by a load from the bus or by stepping it one or two places.

The block also holds the 16-bit program counter. The counter can be incremented, or a jump can load it from two consecutive bus bytes. A program-counter output enable chooses what drives the program-store address. When the enable is high, the counter drives it. When it is low, the page pointer and low counter drive it instead, so constants placed in the program can be fetched with the same pointer arithmetic used for RAM. The program-store bits above the pointer are forced high in that mode, as a pulled-up bus would read.

The memories themselves are outside the block. Every state element resets synchronously on an active-high reset.

Top module: `paged_addr_gen`

## Requirements
- R1: After reset the low counter, page pointer, captured low jump byte and program counter are all zero, so `ram_addr`, `pc_q` and (with `pc_oe`=1) `rom_addr` read 0.
- R2: When `x_load` is high at a clock edge, the low counter takes `bus_in[3:0]` on that edge. This holds whatever `x_step` and `x_step2` are doing.
- R3: Without a load, `x_step2` adds 2 and `x_step` adds 1 to the low counter, modulo 16. If both are high, the result is +2. Wrapping past 15 never changes the page pointer.
- R4: `page_load` copies `bus_in[7:0]` into the page pointer, which appears on `ram_addr[11:4]` after the edge.
- R5: `ram_addr` is always {1'b0, page pointer, low counter}. Bit 12 is constant 0.
- R6: `pc_inc` adds 1 to the program counter modulo 65536.
- R7: `pc_lo_wr` captures `bus_in` as the pending low byte. `pc_jump` loads the program counter with {`bus_in`, pending low byte} and wins over `pc_inc`. A jump issued together with `pc_lo_wr` uses the byte that was pending before that edge.
- R8: With `pc_oe`=1, `rom_addr` is the program counter's bits 14:0. With `pc_oe`=0, it is {3'b111, page pointer, low counter}. The switch is combinational on `pc_oe`.
- R9: The address changes only on the clock edge. During a cycle in which a step strobe is asserted (a RAM read combined with a step), `ram_addr` still shows the address from before the step.
- R10: `pc_q` presents all 16 program counter bits, including bit 15, which no memory address uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 8 | Data bus value for all loads |
| x_load | input | 1 | Load low counter from bus_in[3:0] |
| x_step | input | 1 | Step low counter by one |
| x_step2 | input | 1 | Step low counter by two |
| page_load | input | 1 | Load page pointer from bus |
| pc_inc | input | 1 | Increment program counter |
| pc_lo_wr | input | 1 | Capture jump low byte |
| pc_jump | input | 1 | Load program counter from bus and captured byte |
| pc_oe | input | 1 | 1: program counter drives rom_addr, 0: pointer/counter drive it |
| ram_addr | output | 13 | Data RAM address |
| rom_addr | output | 15 | Program store address |
| pc_q | output | 16 | Full program counter |

## Verification
The bench aims at the low counter wrapping by one and by two. A design that carried the wrap into the pointer would show a changed page there. Colliding strobes are driven on purpose: a load together with steps, a jump together with an increment, and a jump in the same cycle as a low-byte capture. A wrong priority or a forwarded byte gives a different counter or program counter value. The program counter is taken through 0xFFFF to 0, and `rom_addr` is checked in both enable states, so a missing fill or a truncated bit 15 on `pc_q` shows up directly.

// File: rtl/pa_pkg.sv
package pa_pkg;
  typedef enum logic [1:0] {XOP_HOLD, XOP_LOAD, XOP_INC1, XOP_INC2} xop_e;

  function automatic xop_e xop_decode(input logic ld, input logic s1, input logic s2);
    if (ld)      return XOP_LOAD;
    else if (s2) return XOP_INC2;
    else if (s1) return XOP_INC1;
    else         return XOP_HOLD;
  endfunction
endpackage

// File: rtl/pa_xcount.sv
module pa_xcount #(
  parameter int X_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step1,
  input  logic           step2,
  input  logic [X_W-1:0] din,
  output logic [X_W-1:0] x_q
);
  import pa_pkg::*;
  xop_e op;
  assign op = xop_decode(load, step1, step2);

  always_ff @(posedge clk) begin
    if (rst) x_q <= '0;
    else begin
      case (op)
        XOP_LOAD: x_q <= din;
        XOP_INC1: x_q <= x_q + X_W'(1);
        XOP_INC2: x_q <= x_q + X_W'(2);
        default:  x_q <= x_q;
      endcase
    end
  end

  p_load_wins_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (x_q == $past(din)));
  p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && step1 && !step2) |=> (x_q == X_W'($past(x_q) + 1)));
  p_step_two_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && step2) |=> (x_q == X_W'($past(x_q) + 2)));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!load && !step1 && !step2) |=> $stable(x_q));
endmodule

// File: rtl/pa_page.sv
module pa_page #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end

  p_page_load_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(din)));
  p_page_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
endmodule

// File: rtl/pa_pcount.sv
module pa_pcount #(
  parameter int PC_W  = 16,
  parameter int BUS_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inc,
  input  logic            lo_wr,
  input  logic            jump,
  input  logic [BUS_W-1:0] din,
  output logic [PC_W-1:0]  pc_q
);
  localparam int HI_W = PC_W - BUS_W;

  logic [BUS_W-1:0] lo_hold;

  always_ff @(posedge clk) begin
    if (rst)        lo_hold <= '0;
    else if (lo_wr) lo_hold <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)       pc_q <= '0;
    else if (jump) pc_q <= {din[HI_W-1:0], lo_hold};
    else if (inc)  pc_q <= pc_q + PC_W'(1);
  end

  p_jump_hi_r7: assert property (@(posedge clk) disable iff (rst)
    jump |=> (pc_q[PC_W-1:BUS_W] == $past(din[HI_W-1:0])));
  p_inc_r6: assert property (@(posedge clk) disable iff (rst)
    (inc && !jump) |=> (pc_q == PC_W'($past(pc_q) + 1)));
  p_pc_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!inc && !jump) |=> $stable(pc_q));
endmodule

// File: rtl/paged_addr_gen.sv
module paged_addr_gen #(
  parameter int X_W    = 4,
  parameter int PAGE_W = 8,
  parameter int BUS_W  = 8,
  parameter int PC_W   = 16,
  parameter int ROM_AW = 15,
  parameter int RAM_AW = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  bus_in,
  input  logic              x_load,
  input  logic              x_step,
  input  logic              x_step2,
  input  logic              page_load,
  input  logic              pc_inc,
  input  logic              pc_lo_wr,
  input  logic              pc_jump,
  input  logic              pc_oe,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [PC_W-1:0]   pc_q
);
  localparam int OBJ_W    = PAGE_W + X_W;
  localparam int RAM_PAD  = RAM_AW - OBJ_W;
  localparam int ROM_FILL = ROM_AW - OBJ_W;

  logic [X_W-1:0]    x_q;
  logic [PAGE_W-1:0] page_q;
  logic [OBJ_W-1:0]  obj_addr;

  pa_xcount #(.X_W(X_W)) u_x (
    .clk(clk), .rst(rst), .load(x_load), .step1(x_step), .step2(x_step2),
    .din(bus_in[X_W-1:0]), .x_q(x_q)
  );

  pa_page #(.W(PAGE_W)) u_page (
    .clk(clk), .rst(rst), .load(page_load), .din(bus_in[PAGE_W-1:0]), .q(page_q)
  );

  pa_pcount #(.PC_W(PC_W), .BUS_W(BUS_W)) u_pc (
    .clk(clk), .rst(rst), .inc(pc_inc), .lo_wr(pc_lo_wr), .jump(pc_jump),
    .din(bus_in), .pc_q(pc_q)
  );

  assign obj_addr = {page_q, x_q};

  generate
    if (RAM_PAD > 0) begin : g_ram_pad
      assign ram_addr = {{RAM_PAD{1'b0}}, obj_addr};
    end else begin : g_ram_nopad
      assign ram_addr = obj_addr[RAM_AW-1:0];
    end
    if (ROM_FILL > 0) begin : g_rom_fill
      assign rom_addr = pc_oe ? pc_q[ROM_AW-1:0] : {{ROM_FILL{1'b1}}, obj_addr};
    end else begin : g_rom_nofill
      assign rom_addr = pc_oe ? pc_q[ROM_AW-1:0] : obj_addr[ROM_AW-1:0];
    end
  endgenerate

  p_pc_drives_rom_r8: assert property (@(posedge clk) disable iff (rst)
    pc_oe |-> (rom_addr == pc_q[ROM_AW-1:0]));
  p_ptr_drives_rom_r8: assert property (@(posedge clk) disable iff (rst)
    !pc_oe |-> (rom_addr[OBJ_W-1:0] == ram_addr[OBJ_W-1:0]));
  p_ram_msb_zero_r5: assert property (@(posedge clk) disable iff (rst)
    ram_addr[RAM_AW-1] == 1'b0);
  p_wrap_keeps_page_r3: assert property (@(posedge clk) disable iff (rst)
    (!page_load) |=> (ram_addr[OBJ_W-1:X_W] == $past(ram_addr[OBJ_W-1:X_W])));
endmodule

// File: tb/paged_addr_gen_tb.sv
`timescale 1ns/1ps
module paged_addr_gen_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst;
  logic [7:0]  bus_in;
  logic        x_load, x_step, x_step2, page_load, pc_inc, pc_lo_wr, pc_jump, pc_oe;
  logic [12:0] ram_addr;
  logic [14:0] rom_addr;
  logic [15:0] pc_q;

  paged_addr_gen u_dut (
    .clk(clk), .rst(rst), .bus_in(bus_in), .x_load(x_load), .x_step(x_step),
    .x_step2(x_step2), .page_load(page_load), .pc_inc(pc_inc), .pc_lo_wr(pc_lo_wr),
    .pc_jump(pc_jump), .pc_oe(pc_oe), .ram_addr(ram_addr), .rom_addr(rom_addr), .pc_q(pc_q)
  );

  int n_chk = 0;
  int n_bad = 0;
  int m_x = 0, m_page = 0, m_pc = 0, m_stage = 0;
  logic [31:0] rng = 32'h1234_5678;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_ram();
    return m_page * 16 + m_x;
  endfunction

  function automatic int exp_rom();
    return pc_oe ? (m_pc % 32768) : (28672 + m_page * 16 + m_x);
  endfunction

  task automatic compare_all();
    chk("R5 ram_addr", {19'd0, ram_addr}, exp_ram());
    chk("R8 rom_addr", {17'd0, rom_addr}, exp_rom());
    chk("R10 pc_q", {16'd0, pc_q}, m_pc);
  endtask

  task automatic step(input logic [7:0] b, input logic xl, input logic s1, input logic s2,
                      input logic pl, input logic inc, input logic lo, input logic jmp,
                      input logic oe);
    int nx, np, npc, ns;
    bus_in = b; x_load = xl; x_step = s1; x_step2 = s2; page_load = pl;
    pc_inc = inc; pc_lo_wr = lo; pc_jump = jmp; pc_oe = oe;
    nx = m_x; np = m_page; npc = m_pc; ns = m_stage;
    if (xl) nx = b % 16;
    else if (s2) nx = (m_x + 2) % 16;
    else if (s1) nx = (m_x + 1) % 16;
    if (pl) np = b;
    if (lo) ns = b;
    if (jmp) npc = b * 256 + m_stage;
    else if (inc) npc = (m_pc + 1) % 65536;
    #2;
    chk("R9 pre-edge ram_addr", {19'd0, ram_addr}, exp_ram());
    @(posedge clk);
    #1;
    m_x = nx; m_page = np; m_pc = npc; m_stage = ns;
    x_load = 0; x_step = 0; x_step2 = 0; page_load = 0;
    pc_inc = 0; pc_lo_wr = 0; pc_jump = 0;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1; bus_in = 0; x_load = 0; x_step = 0; x_step2 = 0; page_load = 0;
    pc_inc = 0; pc_lo_wr = 0; pc_jump = 0; pc_oe = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk("R1 reset ram_addr", {19'd0, ram_addr}, 0);
    chk("R1 reset rom_addr", {17'd0, rom_addr}, 0);
    chk("R1 reset pc_q", {16'd0, pc_q}, 0);

    step(8'hA5, 0, 0, 0, 1, 0, 0, 0, 1);
    chk("R4 page load", {19'd0, ram_addr}, 32'h0A50);
    step(8'h3E, 1, 1, 1, 0, 0, 0, 0, 1);
    chk("R2 load over steps", {19'd0, ram_addr}, 32'h0A5E);
    step(8'h00, 0, 1, 0, 0, 0, 0, 0, 1);
    step(8'h00, 0, 1, 0, 0, 0, 0, 0, 1);
    chk("R3 wrap by one keeps page", {19'd0, ram_addr}, 32'h0A50);
    step(8'h0E, 1, 0, 0, 0, 0, 0, 0, 1);
    step(8'h00, 0, 0, 1, 0, 0, 0, 0, 1);
    chk("R3 wrap by two keeps page", {19'd0, ram_addr}, 32'h0A50);
    step(8'h00, 0, 1, 1, 0, 0, 0, 0, 1);
    chk("R3 both steps give two", {19'd0, ram_addr}, 32'h0A52);
    step(8'h00, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 pointer drives rom", {17'd0, rom_addr}, 32'h7A52);
    chk("R5 ram bit12 zero", {31'd0, ram_addr[12]}, 0);

    step(8'hFF, 0, 0, 0, 0, 0, 1, 0, 1);
    step(8'hFF, 0, 0, 0, 0, 1, 0, 1, 1);
    chk("R10 pc_q bit15", {16'd0, pc_q}, 32'hFFFF);
    chk("R8 pc drives rom", {17'd0, rom_addr}, 32'h7FFF);
    step(8'h00, 0, 0, 0, 0, 1, 0, 0, 1);
    chk("R6 increment wraps", {16'd0, pc_q}, 0);
    step(8'h34, 0, 0, 0, 0, 0, 1, 0, 1);
    step(8'h12, 0, 0, 0, 0, 1, 1, 1, 1);
    chk("R7 jump uses prior low byte", {16'd0, pc_q}, 32'h1234);
    step(8'h56, 0, 0, 0, 0, 0, 0, 1, 1);
    chk("R7 captured byte reused", {16'd0, pc_q}, 32'h5612);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      r = rng;
      step(r[7:0], r[8] & r[9], r[10], r[11] & r[12], r[13] & r[14],
           r[15], r[16] & r[17], r[18] & r[19] & r[20], r[21] | r[22]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule